// File: doc/BRIEF.md
# Programmable Load-Clock Divider Chain

This block turns a fast input clock into two slower, related clocks. The first stage divides the input clock by one of nine fixed moduli, chosen with a 4-bit select code, and drives the load clock. That stage can instead be silenced, which holds the load clock low, or switched to a fixed divide-by-2. The second stage counts load-clock periods and divides the load clock again by any integer from 1 to 512. Both outputs are registered in the input-clock domain, and every edge of the second-stage clock lines up with a rising edge of the load clock.

Settings do not take effect when the inputs change. They are captured on a synchronous reload pulse, and that pulse also restarts both stages in phase. Changes made while the block is running are therefore not glitch-free. A new setting is applied by presenting it and pulsing `reload`.

The first stage is a four-state machine. STOP is the state after reset, where the block waits for the first reload. HIGH and LOW are the two halves of the load-clock period, and MUTE is the silenced state. Its transitions are as follows. A reload moves any state to HIGH, or to MUTE when the load clock is to be silenced. HIGH moves to LOW and LOW moves back to HIGH when the half-period counter of the current half reaches zero; the move from LOW to HIGH emits a rise pulse. STOP and MUTE stay where they are until a reload.

The second stage is also a four-state machine. OFF is the state after reset and while the load clock is silenced. PASS is used when the second-stage modulus is 1. HIGH and LOW are its two halves. A reload moves it to OFF, PASS or HIGH according to the captured settings. In HIGH and LOW the rise pulse counts a half down, and at zero the state moves to the other half.

Top module: `loadclk_div_chain`

## Requirements
- R1: After reset both `load_clk` and `n2_clk` are low, and they stay low until the first `reload`.
- R2: Select codes 0 to 8 pick first-stage moduli 3, 4, 5, 6, 8, 10, 12, 16 and 20 in that order. The load-clock period is that many input cycles.
- R3: The load clock is high for ceil(N/2) input cycles and low for floor(N/2) cycles. Its first high cycle starts at the input-clock edge that samples `reload`.
- R4: While `suppress` is 1, or while the select code is 9 to 15, `load_clk` is held low. Suppression has priority over bypass.
- R5: With `bypass` set and no suppression, the load-clock period is 2 input cycles whatever the select code.
- R6: For a second-stage modulus M of 2 or more, `n2_clk` has a period of M load-clock periods. It is high for ceil(M/2) of those periods, and every rising edge of `n2_clk` coincides with a rising edge of `load_clk`.
- R7: An `n2_mod` value of 1 makes `n2_clk` equal to `load_clk`. A value of 0 stands for a modulus of 512.
- R8: While the load clock is suppressed, `n2_clk` is held low.
- R9: Changes on `mod_sel`, `suppress`, `bypass` and `n2_mod` have no effect until the next `reload`; the running waveform continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 1 | Synchronous pulse: captures settings and restarts both stages |
| mod_sel | input | 4 | First-stage select code (0..8 valid, 9..15 suppress) |
| suppress | input | 1 | Hold the load clock low |
| bypass | input | 1 | First stage divides by 2 |
| n2_mod | input | 9 | Second-stage modulus, 0 means 512 |
| load_clk | output | 1 | First-stage output clock |
| n2_clk | output | 1 | Second-stage output clock |

## Verification
A wrong half-period count or state in the first stage shows up on `load_clk` as a high or low phase of the wrong length. This appears within one first-stage period, which is at most 20 input cycles after a reload. A fault in the second stage shows up on `n2_clk` only at its next phase change, which can be up to 256 load periods, or 5120 input cycles, after the reload. For that reason the bench watches the largest moduli for two full periods. A configuration captured at the wrong moment appears either in the very first sampled cycle after `reload`, or as a change in the waveform when the inputs move without a reload.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_HIGH,
        ST_LOW,
        ST_MUTE
    } s1_state_t;

    typedef enum logic [1:0] {
        S2_OFF,
        S2_PASS,
        S2_HIGH,
        S2_LOW
    } s2_state_t;

endpackage

// File: rtl/ldc_first_stage.sv
module ldc_first_stage
    import ldc_pkg::*;
#(
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             mute_i,
    input  logic [MOD_W-1:0] n1_i,
    output logic             load_clk_o,
    output logic             rise_o
);
    localparam int HALF_W = MOD_W - 1;

    s1_state_t         st_q, st_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [MOD_W:0]    n1_plus;
    logic [HALF_W-1:0] hi_len, lo_len;

    assign n1_plus = {1'b0, n1_i} + 1'b1;
    assign hi_len  = n1_plus[MOD_W:1];
    assign lo_len  = n1_i[MOD_W-1:1];

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        rise_o = 1'b0;
        if (reload_i) begin
            if (mute_i) begin
                st_d  = ST_MUTE;
                cnt_d = '0;
            end else begin
                st_d  = ST_HIGH;
                cnt_d = hi_len - 1'b1;
            end
        end else begin
            unique case (st_q)
                ST_STOP: ;
                ST_MUTE: ;
                ST_HIGH: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_LOW;
                        cnt_d = lo_len - 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == '0) begin
                        st_d   = ST_HIGH;
                        cnt_d  = hi_len - 1'b1;
                        rise_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        load_clk_o = (st_q == ST_HIGH);
    end

    assert_hi_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && st_q == ST_HIGH) |-> (cnt_q < hi_len));

    assert_lo_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && st_q == ST_LOW) |-> (cnt_q < lo_len));

endmodule

// File: rtl/ldc_second_stage.sv
module ldc_second_stage
    import ldc_pkg::*;
#(
    parameter int M2_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload_i,
    input  logic            mute_i,
    input  logic [M2_W-1:0] m2_i,
    input  logic            rise_i,
    input  logic            load_clk_i,
    output logic            n2_clk_o
);
    localparam int HALF_W = M2_W - 1;

    s2_state_t         st_q, st_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [M2_W:0]     m2_plus;
    logic [HALF_W-1:0] hi_len, lo_len;

    assign m2_plus = {1'b0, m2_i} + 1'b1;
    assign hi_len  = m2_plus[M2_W:1];
    assign lo_len  = m2_i[M2_W-1:1];

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (reload_i) begin
            cnt_d = '0;
            if (mute_i) begin
                st_d = S2_OFF;
            end else if (m2_i == M2_W'(1)) begin
                st_d = S2_PASS;
            end else begin
                st_d  = S2_HIGH;
                cnt_d = hi_len - 1'b1;
            end
        end else begin
            unique case (st_q)
                S2_OFF:  ;
                S2_PASS: ;
                S2_HIGH: begin
                    if (rise_i) begin
                        if (cnt_q == '0) begin
                            st_d  = S2_LOW;
                            cnt_d = lo_len - 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                S2_LOW: begin
                    if (rise_i) begin
                        if (cnt_q == '0) begin
                            st_d  = S2_HIGH;
                            cnt_d = hi_len - 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S2_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        n2_clk_o = (st_q == S2_HIGH) || (st_q == S2_PASS && load_clk_i);
    end

    assert_lo_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && st_q == S2_LOW) |-> (cnt_q < lo_len));

endmodule

// File: rtl/loadclk_div_chain.sv
module loadclk_div_chain #(
    parameter int SEL_W = 4,
    parameter int N2_W  = 9,
    parameter int MOD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [SEL_W-1:0] mod_sel,
    input  logic             suppress,
    input  logic             bypass,
    input  logic [N2_W-1:0]  n2_mod,
    output logic             load_clk,
    output logic             n2_clk
);
    localparam int M2_W     = N2_W + 1;
    localparam int N2_MAX   = 1 << N2_W;
    localparam int NUM_MODS = 9;

    function automatic logic [MOD_W-1:0] code_modulus(input logic [SEL_W-1:0] code);
        case (int'(code))
            0:       return MOD_W'(3);
            1:       return MOD_W'(4);
            2:       return MOD_W'(5);
            3:       return MOD_W'(6);
            4:       return MOD_W'(8);
            5:       return MOD_W'(10);
            6:       return MOD_W'(12);
            7:       return MOD_W'(16);
            8:       return MOD_W'(20);
            default: return MOD_W'(2);
        endcase
    endfunction

    logic             in_mute;
    logic [MOD_W-1:0] in_n1;
    logic [M2_W-1:0]  in_m2;
    logic             cfg_mute, cfg_byp;
    logic [MOD_W-1:0] cfg_n1;
    logic [M2_W-1:0]  cfg_m2;
    logic             use_mute;
    logic [MOD_W-1:0] use_n1;
    logic [M2_W-1:0]  use_m2;
    logic             rise;

    assign in_mute = suppress || (int'(mod_sel) >= NUM_MODS);
    assign in_n1   = bypass ? MOD_W'(2) : code_modulus(mod_sel);
    assign in_m2   = (n2_mod == '0) ? M2_W'(N2_MAX) : {1'b0, n2_mod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mute <= 1'b0;
            cfg_byp  <= 1'b0;
            cfg_n1   <= MOD_W'(2);
            cfg_m2   <= M2_W'(2);
        end else if (reload) begin
            cfg_mute <= in_mute;
            cfg_byp  <= bypass;
            cfg_n1   <= in_n1;
            cfg_m2   <= in_m2;
        end
    end

    assign use_mute = reload ? in_mute : cfg_mute;
    assign use_n1   = reload ? in_n1   : cfg_n1;
    assign use_m2   = reload ? in_m2   : cfg_m2;

    ldc_first_stage #(.MOD_W(MOD_W)) u_first (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .mute_i     (use_mute),
        .n1_i       (use_n1),
        .load_clk_o (load_clk),
        .rise_o     (rise)
    );

    ldc_second_stage #(.M2_W(M2_W)) u_second (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .mute_i     (use_mute),
        .m2_i       (use_m2),
        .rise_i     (rise),
        .load_clk_i (load_clk),
        .n2_clk_o   (n2_clk)
    );

    // R4 and R8: a silenced configuration keeps both clocks low
    assert_mute_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mute |-> (!load_clk && !n2_clk));

    assert_bypass_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_byp && !cfg_mute && !reload) |=> (load_clk != $past(load_clk)));

    assert_n2_rise_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(n2_clk) |-> load_clk);

endmodule

// File: tb/sim_loadclk_div_chain.sv
module sim_loadclk_div_chain;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload = 1'b0;
    logic [3:0] mod_sel = '0;
    logic       suppress = 1'b0;
    logic       bypass = 1'b0;
    logic [8:0] n2_mod = 9'd2;
    logic       load_clk, n2_clk;

    int checks = 0;
    int fails  = 0;
    int mods[9] = '{3, 4, 5, 6, 8, 10, 12, 16, 20};

    always #(CLK_PERIOD/2) clk = ~clk;

    loadclk_div_chain u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .mod_sel  (mod_sel),
        .suppress (suppress),
        .bypass   (bypass),
        .n2_mod   (n2_mod),
        .load_clk (load_clk),
        .n2_clk   (n2_clk)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp, input int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s sample %0d: actual %b expected %b", tag, what, k, act, exp);
        end
    endtask

    task automatic do_reload(input int code, input bit sup, input bit byp, input int field);
        @(negedge clk);
        mod_sel  = 4'(code);
        suppress = sup;
        bypass   = byp;
        n2_mod   = 9'(field);
        reload   = 1'b1;
        @(negedge clk);
        reload   = 1'b0;
    endtask

    // n1: first-stage modulus, m2: second-stage modulus, k0: sample index of the first sample
    task automatic run_check(input int n1, input int m2, input int k0, input int nsamp, input string tag);
        for (int k = k0; k < k0 + nsamp; k++) begin
            logic exp_l, exp_n;
            exp_l = ((k % n1) < (n1 + 1) / 2);
            if (m2 == 1) exp_n = exp_l;
            else         exp_n = ((k % (n1 * m2)) < ((m2 + 1) / 2) * n1);
            check(tag, "load_clk", load_clk, exp_l, k);
            check(tag, "n2_clk", n2_clk, exp_n, k);
            @(negedge clk);
        end
    endtask

    task automatic run_quiet(input int nsamp, input string tag);
        for (int k = 0; k < nsamp; k++) begin
            check(tag, "load_clk", load_clk, 1'b0, k);
            check(tag, "n2_clk", n2_clk, 1'b0, k);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        run_quiet(1, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_quiet(25, "R1 idle");
    endtask

    task automatic t_moduli;
        for (int c = 0; c < 9; c++) begin
            do_reload(c, 1'b0, 1'b0, 3);
            run_check(mods[c], 3, 0, 2 * mods[c] * 3, "R2 R3 R6 modulus");
        end
    endtask

    task automatic t_bypass;
        do_reload(7, 1'b0, 1'b1, 4);
        run_check(2, 4, 0, 16, "R5 bypass code7");
        do_reload(0, 1'b0, 1'b1, 2);
        run_check(2, 2, 0, 12, "R5 bypass code0");
    endtask

    task automatic t_suppress;
        do_reload(3, 1'b1, 1'b0, 2);
        run_quiet(40, "R4 R8 suppress bit");
        do_reload(9, 1'b0, 1'b0, 2);
        run_quiet(30, "R4 code9");
        do_reload(15, 1'b0, 1'b0, 5);
        run_quiet(30, "R4 code15");
        do_reload(2, 1'b1, 1'b1, 2);
        run_quiet(30, "R4 suppress over bypass");
        do_reload(2, 1'b0, 1'b0, 2);
        run_check(5, 2, 0, 20, "R8 resume after suppress");
    endtask

    task automatic t_n2_edges;
        do_reload(1, 1'b0, 1'b0, 1);
        run_check(4, 1, 0, 16, "R7 pass through");
        do_reload(0, 1'b0, 1'b0, 0);
        run_check(3, 512, 0, 2 * 3 * 512, "R7 zero means 512");
        do_reload(8, 1'b0, 1'b0, 5);
        run_check(20, 5, 0, 2 * 20 * 5, "R6 odd modulus");
    endtask

    task automatic t_hold;
        do_reload(0, 1'b0, 1'b0, 5);
        run_check(3, 5, 0, 15, "R9 before change");
        mod_sel  = 4'd8;
        bypass   = 1'b1;
        suppress = 1'b1;
        n2_mod   = 9'd1;
        run_check(3, 5, 15, 45, "R9 inputs changed without reload");
        suppress = 1'b0;
        bypass   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_moduli();
        t_bypass();
        t_suppress();
        t_n2_edges();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule